// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 18-bit ports, A and B, with two independent data paths: one carries A toward B, the other carries B toward A. Each path has its own storage element that acts as a level-sensitive latch while its latch-open control is high and as an edge-triggered register while that control is low. Each path also has its own output enable. When the latch is open, the path output follows its input within the same cycle. When the latch is closed, a rising edge on the path's own clock input loads the input, and the stored value is held until the next such edge.

The block runs in one core clock domain. Each path clock is treated as a sampled strobe, and a low-to-high step seen between two core clock edges counts as one capture. Each port is split into separate input, output and per-bit drive-enable vectors, so a pad wrapper can form the tri-state value without contention. An optional bus keeper (parameter `KEEP_EN`) sits on each data input. A bit whose external driver has let go reads the last value it had while it was driven.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While `rst` is high at a core clock edge, both stored words become 0, both keeper words become 0, and both path clock histories are taken as low.
- R2: While `ab_open` is 1, `b_out` equals the keeper-resolved A word in the same cycle, with no clock edge needed.
- R3: While `ab_open` is 0, a core clock edge at which `ab_strobe` is 1 and was 0 at the previous core edge loads the resolved A word. `b_out` shows that word from this edge on.
- R4: While `ab_open` is 0 and `ab_strobe` stays steadily high or steadily low, `b_out` keeps its stored value. After `ab_open` falls, the stored value is the A word present at the last core edge at which `ab_open` was 1.
- R5: `b_drv` is 18 copies of `ab_drive`, which is active high. The A-to-B storage keeps loading and holding while `b_drv` is all zeros.
- R6: The B-to-A path behaves as R2 to R4 using `ba_open` and `ba_strobe`, with `a_out` as its output. `a_drv` is 18 copies of the inverse of `ba_drive_n`, which is active low.
- R7: With `KEEP_EN`=1, a data bit whose valid bit (`a_vld[i]` or `b_vld[i]`) is 0 resolves to the value that bit had at the last core edge where its valid bit was 1. A bit whose valid bit is 1 resolves to its input in the same cycle.
- R8: The two paths are independent. Controls and data of one path never change the output of the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data sensed on port A |
| a_vld | input | 18 | Per-bit: an external source is driving A |
| b_in | input | 18 | Data sensed on port B |
| b_vld | input | 18 | Per-bit: an external source is driving B |
| ab_open | input | 1 | A-to-B latch open (transparent) |
| ab_strobe | input | 1 | A-to-B capture clock, rising step loads |
| ab_drive | input | 1 | A-to-B output enable, active high |
| ba_open | input | 1 | B-to-A latch open (transparent) |
| ba_strobe | input | 1 | B-to-A capture clock, rising step loads |
| ba_drive_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Data presented toward port B |
| b_drv | output | 18 | Per-bit drive enable for port B |
| a_out | output | 18 | Data presented toward port A |
| a_drv | output | 18 | Per-bit drive enable for port A |

## Verification
The capture and hold properties assume that the path strobes are low while reset is applied, so that the history register cleared by reset agrees with the sampled history the properties read. The stimulus keeps both strobes low during reset. The transparency and capture checks also assume that every valid bit is high, so that the resolved word equals the raw input. The bench changes each strobe, open control and enable only on the falling core clock edge, and it clears valid bits only in the keeper scenario, where open controls are high.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_W = 18;

    // Source selected for a path output
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } path_src_e;

    // Decoded per-path controls, common polarity
    typedef struct packed {
        logic open;   // latch transparent
        logic tick;   // one-cycle capture pulse
        logic drive;  // output enable, active high
    } path_ctrl_t;

    function automatic logic rise_seen(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

    function automatic path_src_e pick_src(input logic open_v);
        return open_v ? SRC_LIVE : SRC_STORED;
    endfunction

endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int unsigned W       = 18,
    parameter bit          KEEP_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] vld,
    output logic [W-1:0] resolved
);

    genvar gi;
    generate
        if (KEEP_EN) begin : g_keep
            logic [W-1:0] last_q;
            for (gi = 0; gi < W; gi++) begin : g_bit
                always_ff @(posedge clk) begin
                    if (rst)
                        last_q[gi] <= 1'b0;
                    else if (vld[gi])
                        last_q[gi] <= raw[gi];
                end
                assign resolved[gi] = vld[gi] ? raw[gi] : last_q[gi];
            end
        end else begin : g_pass
            logic [W-1:0] unused_vld;
            assign unused_vld = vld;
            assign resolved   = raw;
        end
    endgenerate

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int unsigned W      = 18,
    parameter bit          OE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         open_i,
    input  logic         strobe_i,
    input  logic         oe_i,
    output logic [W-1:0] dout,
    output logic [W-1:0] drv
);

    logic       strobe_q;
    logic [W-1:0] store_q;
    path_ctrl_t ctl;
    path_src_e  src;

    generate
        if (OE_LOW) begin : g_oe_low
            assign ctl.drive = ~oe_i;
        end else begin : g_oe_high
            assign ctl.drive = oe_i;
        end
    endgenerate

    always_comb begin
        ctl.open = open_i;
        ctl.tick = rise_seen(strobe_i, strobe_q);
        src      = pick_src(ctl.open);
    end

    // Merged latch / edge register: open tracks, closed loads on a rising strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            store_q  <= '0;
        end else begin
            strobe_q <= strobe_i;
            if (ctl.open || ctl.tick)
                store_q <= din;
        end
    end

    always_comb begin
        unique case (src)
            SRC_LIVE:   dout = din;
            SRC_STORED: dout = store_q;
            default:    dout = store_q;
        endcase
        drv = {W{ctl.drive}};
    end

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W       = XCVR_W,
    parameter bit          KEEP_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_vld,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_vld,
    input  logic         ab_open,
    input  logic         ab_strobe,
    input  logic         ab_drive,
    input  logic         ba_open,
    input  logic         ba_strobe,
    input  logic         ba_drive_n,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drv,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drv
);

    logic [W-1:0] a_res;
    logic [W-1:0] b_res;

    xcvr_keeper #(.W(W), .KEEP_EN(KEEP_EN)) u_keep_a (
        .clk(clk), .rst(rst), .raw(a_in), .vld(a_vld), .resolved(a_res)
    );

    xcvr_keeper #(.W(W), .KEEP_EN(KEEP_EN)) u_keep_b (
        .clk(clk), .rst(rst), .raw(b_in), .vld(b_vld), .resolved(b_res)
    );

    xcvr_path #(.W(W), .OE_LOW(1'b0)) u_path_ab (
        .clk(clk), .rst(rst), .din(a_res),
        .open_i(ab_open), .strobe_i(ab_strobe), .oe_i(ab_drive),
        .dout(b_out), .drv(b_drv)
    );

    xcvr_path #(.W(W), .OE_LOW(1'b1)) u_path_ba (
        .clk(clk), .rst(rst), .din(b_res),
        .open_i(ba_open), .strobe_i(ba_strobe), .oe_i(ba_drive_n),
        .dout(a_out), .drv(a_drv)
    );

endmodule

// File: rtl/xcvr_checks.sv
module xcvr_checks #(
    parameter int unsigned W       = 18,
    parameter bit          KEEP_EN = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_vld,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_vld,
    input logic         ab_open,
    input logic         ab_strobe,
    input logic         ab_drive,
    input logic         ba_open,
    input logic         ba_strobe,
    input logic         ba_drive_n,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_drv,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_drv
);

    p_open_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (ab_open && (&a_vld)) |-> (b_out == a_in));

    p_edge_loads_r3: assert property (@(posedge clk) disable iff (rst)
        (!ab_open && $rose(ab_strobe) && (&a_vld)) |=> (ab_open || b_out == $past(a_in)));

    p_closed_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!ab_open && !$rose(ab_strobe)) |=> (ab_open || $stable(b_out)));

    p_b_enable_r5: assert property (@(posedge clk) disable iff (rst)
        (b_drv == {W{ab_drive}}));

    p_a_enable_r6: assert property (@(posedge clk) disable iff (rst)
        (a_drv == {W{~ba_drive_n}}));

    p_ba_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (!ba_open && !$rose(ba_strobe)) |=> (ba_open || $stable(a_out)));

    generate
        if (KEEP_EN) begin : g_keep_chk
            p_keeper_bit0_r7: assert property (@(posedge clk) disable iff (rst)
                (ab_open && !a_vld[0]) |=> (!(ab_open && !a_vld[0]) || $stable(b_out[0])));
        end
    endgenerate

endmodule

bind reg_bus_xcvr xcvr_checks #(.W(W), .KEEP_EN(KEEP_EN)) u_chk (
    .clk(clk), .rst(rst), .a_in(a_in), .a_vld(a_vld), .b_in(b_in), .b_vld(b_vld),
    .ab_open(ab_open), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
    .ba_open(ba_open), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
);

// File: tb/sim_reg_bus_xcvr.sv
`timescale 1ns/1ps
module sim_reg_bus_xcvr;

    localparam int unsigned W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, a_vld, b_in, b_vld;
    logic         ab_open, ab_strobe, ab_drive;
    logic         ba_open, ba_strobe, ba_drive_n;
    logic [W-1:0] b_out, b_drv, a_out, a_drv;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    reg_bus_xcvr #(.W(W), .KEEP_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .a_vld(a_vld), .b_in(b_in), .b_vld(b_vld),
        .ab_open(ab_open), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
        .ba_open(ba_open), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
        .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    // one core edge, then settle at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        a_in = 18'h2A5A5; b_in = 18'h15A5A;
        a_vld = '1; b_vld = '1;
        ab_open = 1'b0; ab_strobe = 1'b0; ab_drive = 1'b0;
        ba_open = 1'b0; ba_strobe = 1'b0; ba_drive_n = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 b_out after reset", b_out, '0);
        chk("R1 a_out after reset", a_out, '0);
        chk("R5 b_drv disabled", b_drv, '0);
        chk("R6 a_drv disabled", a_drv, '0);
    endtask

    task automatic t_open_ab();
        ab_open = 1'b1;
        a_in = 18'h1F00F;
        #1 chk("R2 transparent first word", b_out, 18'h1F00F);
        a_in = 18'h00FF1;
        #1 chk("R2 transparent second word", b_out, 18'h00FF1);
        chk("R8 a_out untouched by A-to-B", a_out, '0);
        @(negedge clk);
    endtask

    task automatic t_capture_ab();
        ab_open = 1'b1; a_in = 18'h12345;
        step();
        ab_open = 1'b0; a_in = 18'h2BCDE;
        step();
        chk("R4 holds last open word", b_out, 18'h12345);
        ab_strobe = 1'b1;
        step();
        chk("R3 rising strobe loads", b_out, 18'h2BCDE);
        a_in = 18'h0AAAA;
        repeat (3) step();
        chk("R4 steady high strobe holds", b_out, 18'h2BCDE);
        ab_strobe = 1'b0;
        repeat (2) step();
        chk("R4 falling and low strobe holds", b_out, 18'h2BCDE);
        a_in = 18'h35555;
        ab_strobe = 1'b1;
        step();
        chk("R3 second rising strobe loads", b_out, 18'h35555);
        ab_strobe = 1'b0;
        step();
    endtask

    task automatic t_enable_ab();
        ab_drive = 1'b0;
        a_in = 18'h3C3C3;
        ab_strobe = 1'b1;
        step();
        chk("R5 drv low while disabled", b_drv, '0);
        ab_strobe = 1'b0;
        a_in = 18'h00001;
        step();
        ab_drive = 1'b1;
        #1 chk("R5 drv all ones enabled", b_drv, '1);
        chk("R5 load kept while disabled", b_out, 18'h3C3C3);
        @(negedge clk);
    endtask

    task automatic t_path_ba();
        ba_drive_n = 1'b0;
        #1 chk("R6 a_drv active low enable", a_drv, '1);
        ba_open = 1'b1; b_in = 18'h0F0F0;
        #1 chk("R6 B-to-A transparent", a_out, 18'h0F0F0);
        step();
        ba_open = 1'b0; b_in = 18'h22222;
        step();
        chk("R6 B-to-A holds last open word", a_out, 18'h0F0F0);
        ba_strobe = 1'b1;
        step();
        chk("R6 B-to-A rising strobe loads", a_out, 18'h22222);
        chk("R8 b_out untouched by B-to-A", b_out, 18'h3C3C3);
        ba_strobe = 1'b0;
        ba_drive_n = 1'b1;
        #1 chk("R6 a_drv released", a_drv, '0);
        @(negedge clk);
    endtask

    task automatic t_keeper();
        ab_open = 1'b1;
        a_in = 18'h2D2D2;
        a_vld = '1;
        step();
        a_vld = 18'h3FE00;
        a_in = ~18'h2D2D2;
        #1 chk("R7 released bits kept", b_out, {~18'h2D2D2} & 18'h3FE00 | 18'h2D2D2 & 18'h001FF);
        repeat (3) step();
        chk("R7 kept across cycles", b_out, {~18'h2D2D2} & 18'h3FE00 | 18'h2D2D2 & 18'h001FF);
        a_vld = '1;
        #1 chk("R7 driven bits pass", b_out, ~18'h2D2D2);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_open_ab();
        t_capture_ab();
        t_enable_ab();
        t_path_ba();
        t_keeper();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule